// File: doc/BRIEF.md
# Interrupt Entry Stack Sequencer

This block drives the bus cycles a processor core runs when it enters an interrupt or a trap. Four hardware sources (reset request, abort, non-maskable interrupt, maskable interrupt) and two software traps (break and coprocessor) feed it. When it is idle and a request is present, it captures the caller's context (program bank, 16-bit program counter, status byte, 16-bit stack pointer and an emulation-mode flag) and then walks through a fixed cycle sequence: two opening cycles, the pushes of the return context into bank 0 of the stack, and a two-byte vector read with the vector-pull strobe low.

When the vector high byte has been read, the block pulses `done` for one cycle and presents the new program counter (the fetched vector), a cleared program bank, the adjusted status byte and the decremented stack pointer. These result outputs hold until the next entry completes. Software traps arrive on a valid/ready pair; hardware sources are plain level inputs that the owner keeps high until `busy` is seen and then drops.

Back-pressure rules: a trap is taken on a clock edge where `trap_valid` and `trap_ready` are both high. `trap_ready` is high only when the sequencer is idle and no unmasked hardware source is active; a trap that is not taken must keep `trap_valid` high to be served later. The result side has no back-pressure: `done` is a single-cycle pulse and the result outputs are registered.

Top module: `irq_entry_seq`

## Requirements
- R1: A hardware entry opens with two read cycles at {bank, PC}: the first with vda=1 and vpa=1, the second with vda=0 and vpa=0; the pushed return address is the PC unchanged.
- R2: A software trap opens with an opcode read at {bank, PC} (vda=1, vpa=1) and then a signature read at {bank, PC+1} (vda=0, vpa=1); the pushed return address is PC+2.
- R3: In native mode (emu=0) the pushes are bank to {0,S}, PC high to {0,S-1}, PC low to {0,S-2}, status to {0,S-3}, each with vda=1, vpa=0, rw=0, for eight bus cycles in total.
- R4: In emulation mode (emu=1) the bank push is skipped: PC high to {0,S}, PC low to {0,S-1}, status to {0,S-2}, for seven bus cycles in total.
- R5: The vector is read low byte at {0,V} then high byte at {0,V+1} with vda=1, vpa=0, rw=1, and vp_n low only in these two cycles. V is native: reset FFFC, abort FFE8, NMI FFEA, IRQ FFEE, break FFE6, coprocessor FFE4; emulation: reset FFFC, abort FFF8, NMI FFFA, IRQ FFFE, break FFFE, coprocessor FFF4.
- R6: The cycle after the vector high read, `done` is high for exactly one cycle, new_pc equals {high byte, low byte} of the vector and new_bank is 0.
- R7: For a reset entry, rw stays 1 in every push cycle, so nothing is written.
- R8: The pushed status byte equals the captured status in native mode; in emulation mode its bit 4 is 1 for the break trap and 0 for every other source.
- R9: new_status is the captured status with bit 2 (interrupt disable) set and bit 3 (decimal) cleared; new_sp is the captured stack pointer minus the number of pushes, modulo 2^16.
- R10: Requests present together are served in the order reset, abort, NMI, IRQ, then a software trap.
- R11: An IRQ request is ignored while bit 2 of the status input is set: no bus cycle starts and trap_ready stays high.
- R12: trap_ready is high only while idle with no unmasked hardware request; it is low during the whole entry.
- R13: Idle bus state (after reset and between entries): vda=0, vpa=0, rw=1, vp_n=1, busy=0, done=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset of the sequencer |
| reset_req | input | 1 | Processor reset entry request (highest priority) |
| abort_req | input | 1 | Abort entry request |
| nmi_req | input | 1 | Non-maskable interrupt request |
| irq_req | input | 1 | Maskable interrupt request |
| trap_valid | input | 1 | Software trap offered |
| trap_cop | input | 1 | Trap kind: 1 coprocessor, 0 break |
| trap_ready | output | 1 | Software trap can be taken this cycle |
| ctx_bank | input | 8 | Current program bank |
| ctx_pc | input | 16 | Current program counter |
| ctx_status | input | 8 | Current status byte |
| ctx_sp | input | 16 | Current stack pointer |
| ctx_emu | input | 1 | Emulation-mode flag |
| bus_addr | output | 24 | Bus address {bank, offset} |
| bus_wdata | output | 8 | Write data for push cycles |
| bus_rdata | input | 8 | Read data |
| bus_rw | output | 1 | 1 read, 0 write |
| bus_vda | output | 1 | Data address valid |
| bus_vpa | output | 1 | Program address valid |
| bus_vp_n | output | 1 | Vector pull, active low |
| busy | output | 1 | Entry sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| new_bank | output | 8 | Program bank after entry (0) |
| new_pc | output | 16 | Program counter after entry |
| new_status | output | 8 | Status byte after entry |
| new_sp | output | 16 | Stack pointer after entry |

## Verification
The functions that share a cycle are request arbitration and trap acceptance: in the idle cycle a hardware level and a trap offer, or two hardware levels, can arrive on the same edge. The bench raises such pairs together (NMI with IRQ, reset with abort, a trap with IRQ, IRQ while masked) and judges the winner from the vector address read and the opening cycle shape, and checks that `trap_ready` dropped so the trap was not taken. Every bus cycle of each entry is compared against a model built from the requirements.

// File: rtl/ie_pkg.sv
package ie_pkg;
  typedef enum logic [2:0] {
    K_RESET = 3'd0,
    K_ABORT = 3'd1,
    K_NMI   = 3'd2,
    K_IRQ   = 3'd3,
    K_BRK   = 3'd4,
    K_COP   = 3'd5
  } entry_kind_e;

  typedef enum logic [3:0] {
    ST_IDLE      = 4'd0,
    ST_FETCH0    = 4'd1,
    ST_FETCH1    = 4'd2,
    ST_PUSH_BANK = 4'd3,
    ST_PUSH_PCH  = 4'd4,
    ST_PUSH_PCL  = 4'd5,
    ST_PUSH_STAT = 4'd6,
    ST_VEC_LO    = 4'd7,
    ST_VEC_HI    = 4'd8,
    ST_DONE      = 4'd9
  } step_e;

  localparam int IRQ_OFF_BIT = 2;
  localparam int DEC_BIT     = 3;
  localparam int BRK_BIT     = 4;
  localparam int N_HW        = 4;
endpackage

// File: rtl/ie_prio_arb.sv
module ie_prio_arb #(
  parameter int N_SRC = 4
) (
  input  logic [N_SRC-1:0] req,
  output logic [N_SRC-1:0] grant,
  output logic             any
);
  logic blocked;

  // index 0 is the highest priority
  always_comb begin
    blocked = 1'b0;
    grant   = '0;
    for (int i = 0; i < N_SRC; i++) begin
      grant[i] = req[i] & ~blocked;
      blocked  = blocked | req[i];
    end
  end

  assign any = |req;
endmodule

// File: rtl/ie_step_fsm.sv
module ie_step_fsm
  import ie_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  entry_kind_e start_kind,
  input  logic        start_emu,
  input  logic        start_irq_off,
  output step_e       step,
  output entry_kind_e kind_q,
  output logic        emu_q
);
  step_e step_nx;

  always_comb begin
    step_nx = step;
    unique case (step)
      ST_IDLE:      if (start) step_nx = ST_FETCH0;
      ST_FETCH0:    step_nx = ST_FETCH1;
      ST_FETCH1:    step_nx = emu_q ? ST_PUSH_PCH : ST_PUSH_BANK;
      ST_PUSH_BANK: step_nx = ST_PUSH_PCH;
      ST_PUSH_PCH:  step_nx = ST_PUSH_PCL;
      ST_PUSH_PCL:  step_nx = ST_PUSH_STAT;
      ST_PUSH_STAT: step_nx = ST_VEC_LO;
      ST_VEC_LO:    step_nx = ST_VEC_HI;
      ST_VEC_HI:    step_nx = ST_DONE;
      ST_DONE:      step_nx = ST_IDLE;
      default:      step_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      step   <= ST_IDLE;
      kind_q <= K_RESET;
      emu_q  <= 1'b0;
    end else begin
      step <= step_nx;
      if (step == ST_IDLE && start) begin
        kind_q <= start_kind;
        emu_q  <= start_emu;
      end
    end
  end

  // R11: a masked IRQ never launches an entry
  a_r11_irq_masked: assert property (@(posedge clk) disable iff (!rst_n)
    (step == ST_IDLE && start && start_kind == K_IRQ) |-> !start_irq_off);

  // R5: the high vector read always follows the low one
  a_r5_vec_hi_follows: assert property (@(posedge clk) disable iff (!rst_n)
    (step == ST_VEC_LO) |=> (step == ST_VEC_HI));

  // R4: emulation entries never visit the bank push
  a_r4_emu_no_bank: assert property (@(posedge clk) disable iff (!rst_n)
    (step == ST_PUSH_BANK) |-> !emu_q);
endmodule

// File: rtl/ie_bus_fmt.sv
module ie_bus_fmt
  import ie_pkg::*;
#(
  parameter int PC_W    = 16,
  parameter int BANK_W  = 8,
  parameter int DATA_W  = 8,
  parameter logic [PC_W-1:0] VN_RESET = 16'hFFFC,
  parameter logic [PC_W-1:0] VN_ABORT = 16'hFFE8,
  parameter logic [PC_W-1:0] VN_NMI   = 16'hFFEA,
  parameter logic [PC_W-1:0] VN_IRQ   = 16'hFFEE,
  parameter logic [PC_W-1:0] VN_BRK   = 16'hFFE6,
  parameter logic [PC_W-1:0] VN_COP   = 16'hFFE4,
  parameter logic [PC_W-1:0] VE_RESET = 16'hFFFC,
  parameter logic [PC_W-1:0] VE_ABORT = 16'hFFF8,
  parameter logic [PC_W-1:0] VE_NMI   = 16'hFFFA,
  parameter logic [PC_W-1:0] VE_IRQ   = 16'hFFFE,
  parameter logic [PC_W-1:0] VE_BRK   = 16'hFFFE,
  parameter logic [PC_W-1:0] VE_COP   = 16'hFFF4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  step_e                  step,
  input  entry_kind_e            kind,
  input  logic                   emu,
  input  logic [BANK_W-1:0]      bank,
  input  logic [PC_W-1:0]        pc,
  input  logic [DATA_W-1:0]      status,
  input  logic [PC_W-1:0]        sp,
  output logic [BANK_W+PC_W-1:0] addr,
  output logic [DATA_W-1:0]      wdata,
  output logic                   rw,
  output logic                   vda,
  output logic                   vpa,
  output logic                   vp_n
);
  localparam logic [BANK_W-1:0] ZERO_BANK = '0;

  logic              is_sw;
  logic [PC_W-1:0]   ret_pc;
  logic [PC_W-1:0]   push_off;
  logic [PC_W-1:0]   vec;
  logic [DATA_W-1:0] pushed_stat;

  assign is_sw  = (kind == K_BRK) || (kind == K_COP);
  assign ret_pc = is_sw ? pc + PC_W'(2) : pc;

  always_comb begin
    pushed_stat = status;
    if (emu) pushed_stat[BRK_BIT] = (kind == K_BRK);
  end

  always_comb begin
    unique case (kind)
      K_RESET: vec = emu ? VE_RESET : VN_RESET;
      K_ABORT: vec = emu ? VE_ABORT : VN_ABORT;
      K_NMI:   vec = emu ? VE_NMI   : VN_NMI;
      K_IRQ:   vec = emu ? VE_IRQ   : VN_IRQ;
      K_BRK:   vec = emu ? VE_BRK   : VN_BRK;
      K_COP:   vec = emu ? VE_COP   : VN_COP;
      default: vec = VN_RESET;
    endcase
  end

  // distance below the captured stack pointer of each push slot
  always_comb begin
    unique case (step)
      ST_PUSH_PCH:  push_off = emu ? PC_W'(0) : PC_W'(1);
      ST_PUSH_PCL:  push_off = emu ? PC_W'(1) : PC_W'(2);
      ST_PUSH_STAT: push_off = emu ? PC_W'(2) : PC_W'(3);
      default:      push_off = '0;
    endcase
  end

  always_comb begin
    addr  = '0;
    wdata = '0;
    rw    = 1'b1;
    vda   = 1'b0;
    vpa   = 1'b0;
    vp_n  = 1'b1;
    unique case (step)
      ST_FETCH0: begin
        addr = {bank, pc};
        vda  = 1'b1;
        vpa  = 1'b1;
      end
      ST_FETCH1: begin
        addr = is_sw ? {bank, pc + PC_W'(1)} : {bank, pc};
        vpa  = is_sw;
      end
      ST_PUSH_BANK, ST_PUSH_PCH, ST_PUSH_PCL, ST_PUSH_STAT: begin
        addr = {ZERO_BANK, sp - push_off};
        vda  = 1'b1;
        rw   = (kind == K_RESET);
        unique case (step)
          ST_PUSH_BANK: wdata = DATA_W'(bank);
          ST_PUSH_PCH:  wdata = ret_pc[PC_W-1 -: DATA_W];
          ST_PUSH_PCL:  wdata = ret_pc[DATA_W-1:0];
          default:      wdata = pushed_stat;
        endcase
      end
      ST_VEC_LO: begin
        addr = {ZERO_BANK, vec};
        vda  = 1'b1;
        vp_n = 1'b0;
      end
      ST_VEC_HI: begin
        addr = {ZERO_BANK, vec + PC_W'(1)};
        vda  = 1'b1;
        vp_n = 1'b0;
      end
      default: ;
    endcase
  end

  // R5: the vector strobe only accompanies data reads
  a_r5_vp_only_vector: assert property (@(posedge clk) disable iff (!rst_n)
    !vp_n |-> (rw && vda && !vpa));

  // R3: native pushes of non-reset entries are writes to bank 0
  a_r3_push_writes: assert property (@(posedge clk) disable iff (!rst_n)
    (step == ST_PUSH_STAT && kind != K_RESET) |-> (!rw && addr[BANK_W+PC_W-1 -: BANK_W] == ZERO_BANK));
endmodule

// File: rtl/irq_entry_seq.sv
module irq_entry_seq
  import ie_pkg::*;
#(
  parameter int PC_W   = 16,
  parameter int BANK_W = 8,
  parameter int DATA_W = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   reset_req,
  input  logic                   abort_req,
  input  logic                   nmi_req,
  input  logic                   irq_req,
  input  logic                   trap_valid,
  input  logic                   trap_cop,
  output logic                   trap_ready,
  input  logic [BANK_W-1:0]      ctx_bank,
  input  logic [PC_W-1:0]        ctx_pc,
  input  logic [DATA_W-1:0]      ctx_status,
  input  logic [PC_W-1:0]        ctx_sp,
  input  logic                   ctx_emu,
  output logic [BANK_W+PC_W-1:0] bus_addr,
  output logic [DATA_W-1:0]      bus_wdata,
  input  logic [DATA_W-1:0]      bus_rdata,
  output logic                   bus_rw,
  output logic                   bus_vda,
  output logic                   bus_vpa,
  output logic                   bus_vp_n,
  output logic                   busy,
  output logic                   done,
  output logic [BANK_W-1:0]      new_bank,
  output logic [PC_W-1:0]        new_pc,
  output logic [DATA_W-1:0]      new_status,
  output logic [PC_W-1:0]        new_sp
);
  localparam logic [PC_W-1:0] PUSH_NATIVE = PC_W'(4);
  localparam logic [PC_W-1:0] PUSH_EMU    = PC_W'(3);

  logic [N_HW-1:0]   hw_raw;
  logic [N_HW-1:0]   hw_grant;
  logic              hw_any;
  entry_kind_e       hw_kind;
  entry_kind_e       pick_kind;
  logic              idle;
  logic              start;
  step_e             step;
  entry_kind_e       kind_q;
  logic              emu_q;
  logic [BANK_W-1:0] bank_q;
  logic [PC_W-1:0]   pc_q;
  logic [DATA_W-1:0] stat_q;
  logic [PC_W-1:0]   sp_q;
  logic [DATA_W-1:0] vec_lo_q;

  assign hw_raw = {irq_req & ~ctx_status[IRQ_OFF_BIT], nmi_req, abort_req, reset_req};

  ie_prio_arb #(.N_SRC(N_HW)) u_arb (
    .req   (hw_raw),
    .grant (hw_grant),
    .any   (hw_any)
  );

  always_comb begin
    hw_kind = K_RESET;
    for (int i = N_HW - 1; i >= 0; i--)
      if (hw_grant[i]) hw_kind = entry_kind_e'(3'(i));
  end

  assign idle       = (step == ST_IDLE);
  assign trap_ready = idle && !hw_any;
  assign start      = idle && (hw_any || trap_valid);
  assign pick_kind  = hw_any ? hw_kind : (trap_cop ? K_COP : K_BRK);
  assign busy       = !idle;
  assign done       = (step == ST_DONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bank_q <= '0;
      pc_q   <= '0;
      stat_q <= '0;
      sp_q   <= '0;
    end else if (start) begin
      bank_q <= ctx_bank;
      pc_q   <= ctx_pc;
      stat_q <= ctx_status;
      sp_q   <= ctx_sp;
    end
  end

  ie_step_fsm u_fsm (
    .clk           (clk),
    .rst_n         (rst_n),
    .start         (start),
    .start_kind    (pick_kind),
    .start_emu     (ctx_emu),
    .start_irq_off (ctx_status[IRQ_OFF_BIT]),
    .step          (step),
    .kind_q        (kind_q),
    .emu_q         (emu_q)
  );

  ie_bus_fmt #(.PC_W(PC_W), .BANK_W(BANK_W), .DATA_W(DATA_W)) u_fmt (
    .clk    (clk),
    .rst_n  (rst_n),
    .step   (step),
    .kind   (kind_q),
    .emu    (emu_q),
    .bank   (bank_q),
    .pc     (pc_q),
    .status (stat_q),
    .sp     (sp_q),
    .addr   (bus_addr),
    .wdata  (bus_wdata),
    .rw     (bus_rw),
    .vda    (bus_vda),
    .vpa    (bus_vpa),
    .vp_n   (bus_vp_n)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vec_lo_q   <= '0;
      new_bank   <= '0;
      new_pc     <= '0;
      new_status <= '0;
      new_sp     <= '0;
    end else begin
      if (step == ST_VEC_LO) vec_lo_q <= bus_rdata;
      if (step == ST_VEC_HI) begin
        new_pc                  <= {bus_rdata, vec_lo_q};
        new_bank                <= '0;
        new_status              <= stat_q;
        new_status[IRQ_OFF_BIT] <= 1'b1;
        new_status[DEC_BIT]     <= 1'b0;
        new_sp                  <= sp_q - (emu_q ? PUSH_EMU : PUSH_NATIVE);
      end
    end
  end

  // R7: a reset entry never drives a write
  a_r7_reset_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && kind_q == K_RESET) |-> bus_rw);

  // R6: completion is a single-cycle pulse followed by idle
  a_r6_done_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!done && !busy));

  // R12: no trap is offered acceptance while an entry runs
  a_r12_no_ready_busy: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !trap_ready);
endmodule

// File: tb/test_irq_entry_seq.sv
`timescale 1ns/1ps
module test_irq_entry_seq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reset_req = 1'b0, abort_req = 1'b0, nmi_req = 1'b0, irq_req = 1'b0;
  logic        trap_valid = 1'b0, trap_cop = 1'b0;
  logic        trap_ready;
  logic [7:0]  ctx_bank = '0;
  logic [15:0] ctx_pc = '0;
  logic [7:0]  ctx_status = '0;
  logic [15:0] ctx_sp = '0;
  logic        ctx_emu = 1'b0;
  logic [23:0] bus_addr;
  logic [7:0]  bus_wdata, bus_rdata;
  logic        bus_rw, bus_vda, bus_vpa, bus_vp_n, busy, done;
  logic [7:0]  new_bank, new_status;
  logic [15:0] new_pc, new_sp;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;

  always #10 clk = ~clk;

  function automatic logic [7:0] mem_byte(input logic [23:0] a);
    return a[7:0] * 8'd3 + a[15:8] + 8'h11;
  endfunction
  assign bus_rdata = mem_byte(bus_addr);

  irq_entry_seq i_irq_entry_seq (.*);

  typedef struct {
    logic [23:0] a;
    logic vda, vpa, rw, vpn;
    logic [7:0] wd;
    logic cw;
    string req;
  } cyc_t;
  cyc_t exp_q[$];

  task automatic add(input logic [23:0] a, input logic vda, vpa, rw, vpn,
                     input logic [7:0] wd, input logic cw, input string req);
    cyc_t c;
    c.a = a; c.vda = vda; c.vpa = vpa; c.rw = rw; c.vpn = vpn;
    c.wd = wd; c.cw = cw; c.req = req;
    exp_q.push_back(c);
  endtask

  // kinds: 0 reset, 1 abort, 2 nmi, 3 irq, 4 break, 5 coprocessor
  function automatic logic [15:0] vec_of(input int k, input bit emu);
    case (k)
      0: return 16'hFFFC;
      1: return emu ? 16'hFFF8 : 16'hFFE8;
      2: return emu ? 16'hFFFA : 16'hFFEA;
      3: return emu ? 16'hFFFE : 16'hFFEE;
      4: return emu ? 16'hFFFE : 16'hFFE6;
      default: return emu ? 16'hFFF4 : 16'hFFE4;
    endcase
  endfunction

  task automatic chk(input bit ok, input string req, input string msg);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s", req, msg);
    end
  endtask

  task automatic check_idle(input string req);
    chk(bus_vda == 0 && bus_vpa == 0 && bus_rw == 1 && bus_vp_n == 1 && busy == 0 && done == 0,
        req, $sformatf("idle bus: got vda=%b vpa=%b rw=%b vp_n=%b busy=%b done=%b exp 0 0 1 1 0 0",
                       bus_vda, bus_vpa, bus_rw, bus_vp_n, busy, done));
  endtask

  task automatic run_case(input bit rr, ar, nr, ir, tv, tc, input int win,
                          input logic [7:0] bank, input logic [15:0] pc,
                          input logic [7:0] st, input logic [15:0] sp, input bit emu);
    logic [15:0] s, ret, va;
    logic [7:0]  pst, exp_stat;
    bit sw, wr;
    string pr;
    sw  = (win >= 4);
    wr  = (win != 0);
    s   = sp;
    ret = sw ? pc + 16'd2 : pc;
    va  = vec_of(win, emu);
    pst = st;
    if (emu) pst[4] = (win == 4);
    pr  = emu ? "R4" : "R3";
    exp_q.delete();
    add({bank, pc}, 1, 1, 1, 1, 8'h00, 0, sw ? "R2" : "R1");
    if (sw) add({bank, pc + 16'd1}, 0, 1, 1, 1, 8'h00, 0, "R2");
    else    add({bank, pc}, 0, 0, 1, 1, 8'h00, 0, "R1");
    if (!emu) begin add({8'h00, s}, 1, 0, !wr, 1, bank, wr, "R3"); s = s - 16'd1; end
    add({8'h00, s}, 1, 0, !wr, 1, ret[15:8], wr, wr ? pr : "R7"); s = s - 16'd1;
    add({8'h00, s}, 1, 0, !wr, 1, ret[7:0], wr, wr ? pr : "R7"); s = s - 16'd1;
    add({8'h00, s}, 1, 0, !wr, 1, pst, wr, wr ? "R8" : "R7"); s = s - 16'd1;
    add({8'h00, va}, 1, 0, 1, 0, 8'h00, 0, "R5");
    add({8'h00, va + 16'd1}, 1, 0, 1, 0, 8'h00, 0, "R5");

    ctx_bank = bank; ctx_pc = pc; ctx_status = st; ctx_sp = sp; ctx_emu = emu;
    reset_req = rr; abort_req = ar; nmi_req = nr; irq_req = ir;
    trap_valid = tv; trap_cop = tc;
    #1;
    if (tv) chk(trap_ready == !(rr | ar | nr | (ir & ~st[2])), "R12",
                $sformatf("trap_ready got %b", trap_ready));
    @(posedge clk);
    @(negedge clk);
    reset_req = 0; abort_req = 0; nmi_req = 0; irq_req = 0; trap_valid = 0;
    foreach (exp_q[i]) begin
      cyc_t e = exp_q[i];
      chk(bus_addr === e.a && bus_vda === e.vda && bus_vpa === e.vpa && bus_rw === e.rw &&
          bus_vp_n === e.vpn && (!e.cw || bus_wdata === e.wd) && busy === 1 && trap_ready === 0,
          (win == 0 && i == 0) ? "R10" : e.req,
          $sformatf("cycle %0d: got a=%h vda=%b vpa=%b rw=%b vp_n=%b wd=%h busy=%b rdy=%b exp a=%h vda=%b vpa=%b rw=%b vp_n=%b wd=%h busy=1 rdy=0",
                    i, bus_addr, bus_vda, bus_vpa, bus_rw, bus_vp_n, bus_wdata, busy, trap_ready,
                    e.a, e.vda, e.vpa, e.rw, e.vpn, e.wd));
      @(negedge clk);
    end
    exp_stat = (st | 8'h04) & ~8'h08;
    chk(done == 1 && new_pc == {mem_byte({8'h00, va + 16'd1}), mem_byte({8'h00, va})} && new_bank == 0,
        "R6", $sformatf("done=%b pc=%h bank=%h exp 1 %h 00", done, new_pc, new_bank,
                        {mem_byte({8'h00, va + 16'd1}), mem_byte({8'h00, va})}));
    chk(new_status == exp_stat && new_sp == s, "R9",
        $sformatf("status=%h sp=%h exp %h %h", new_status, new_sp, exp_stat, s));
    @(negedge clk);
    check_idle("R6");
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      n_fail++;
      $display("FAIL watchdog expired (all requirements)");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check_idle("R13");
    chk(trap_ready == 1, "R13", $sformatf("trap_ready got %b exp 1", trap_ready));

    // R7 reset entry in emulation mode
    run_case(1,0,0,0,0,0, 0, 8'h12, 16'h3456, 8'h30, 16'h01FF, 1);
    // R1 R3 R5 NMI native
    run_case(0,0,1,0,0,0, 2, 8'h7E, 16'h8000, 8'h0B, 16'h1FF0, 0);
    // R4 R8 IRQ emulation, bit4 cleared
    run_case(0,0,0,1,0,0, 3, 8'h00, 16'hC123, 8'h30, 16'h01FD, 1);
    // R2 R8 break trap emulation, bit4 set
    run_case(0,0,0,0,1,0, 4, 8'h00, 16'hE0FF, 8'h20, 16'h01F0, 1);
    // R2 coprocessor trap native, PC carry into high byte
    run_case(0,0,0,0,1,1, 5, 8'h05, 16'h12FE, 8'hC9, 16'h0400, 0);
    // R9 abort native with stack wrap
    run_case(0,1,0,0,0,0, 1, 8'hA0, 16'h0042, 8'h08, 16'h0001, 0);
    // R10 NMI beats IRQ in the same cycle
    run_case(0,0,1,1,0,0, 2, 8'h01, 16'h2000, 8'h00, 16'h0300, 0);
    // R10 reset beats abort
    run_case(1,1,0,0,0,0, 0, 8'h02, 16'h3000, 8'h00, 16'h0200, 0);
    // R10 R12 IRQ beats a trap offered together
    run_case(0,0,0,1,1,0, 3, 8'h03, 16'h4000, 8'h81, 16'h0500, 0);

    // R11 masked IRQ is ignored
    ctx_status = 8'h04;
    irq_req = 1'b1;
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      check_idle("R11");
      chk(trap_ready == 1, "R11", $sformatf("trap_ready got %b exp 1", trap_ready));
    end
    irq_req = 1'b0;
    @(negedge clk);
    check_idle("R13");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end
endmodule